// File: doc/BRIEF.md
# Serial-addressed 8-bit port expander

This block is an SPI target that gives a host eight general-purpose pins, each of which can be an input or an output. Three internal registers can be reached over the serial link. A direction register chooses, bit by bit, whether a pin is driven. A data register holds the values driven onto output pins. A control register arms a port comparator and holds its flag. Pins are modelled as separate input, output and output-enable vectors. MISO is modelled as a data bit plus an enable, where a low enable stands for high impedance.

Every frame is sixteen bits. A command byte comes first and a data byte follows, most significant bit first. The command byte carries a two-bit identity, so four of these blocks can share a single chip-select line, and only the block whose identity pins match responds. The clock level seen at the moment chip-select goes active fixes the clock polarity for that frame. While the command byte is being clocked in, the block shifts the control register out, so the comparator flag reaches the host in every frame without a separate status read. Writes to the data register can replace its value, set selected bits, or clear selected bits. The comparator checks the live pins against the data register under one of four conditions. Its flag stays set until the control register is read.

SCK, MOSI and chip-select are sampled with the system clock through two-stage synchronisers, and SCK must run at no more than a quarter of the system clock rate.

Top module: `spi_gpio_expander`

## Requirements
- R1: After reset the data, direction and control registers are zero, so `pin_oe_o` and `pin_o` are all zero and `miso_oe_o` is low.
- R2: Command byte: bit 7 is 1 for a write and 0 for a read, bits 6:5 are the identity, bits 4:3 select the register (00 data, 01 direction, 10 control, 11 reads as zero), bit 2 is ignored, and bits 1:0 are the write mode. The data byte follows. A read returns the selected register in the data byte.
- R3: When bits 6:5 of the command differ from `id_i`, the frame changes no register and `miso_oe_o` stays low for the whole frame.
- R4: The SCK level present when `cs_n_i` falls is latched. Idle-low frames sample MOSI on rising edges and idle-high frames sample on falling edges. MISO changes on the opposite edge, and both directions carry the most significant bit first.
- R5: `miso_oe_o` is low whenever chip-select is inactive. Within a matching frame it rises only once both identity bits have been received.
- R6: Data register writes use mode 00 or 11 to replace the value, mode 01 to OR the byte in, and mode 10 to AND with the inverted byte. Registers change only on a write.
- R7: A read of the data register returns the register bit for pins set as outputs and the synchronised pin level for pins set as inputs.
- R8: `pin_o` always equals the data register and `pin_oe_o` always equals the direction register.
- R9: Control bits 1:0 select the compare condition: 00 pins equal the data register, 01 any bit differs, 10 pins greater than the register (unsigned), 11 pins less than the register. When control bit 2 is set and the condition holds, the flag is set.
- R10: The flag is sticky. It clears only when the control register is read, after its value has been shifted out in that read.
- R11: During the command byte of every frame, MISO carries the control register as it reads back: bit 4 the flag, bit 2 the enable, bits 1:0 the condition, and all other bits zero.
- R12: A frame in which chip-select is released before the sixteenth bit changes no register.
- R13: A control register write stores only bits 2 and 1:0. The flag bit and the other bits written by the host are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| id_i | input | 2 | Identity of this block, matched against command bits 6:5 |
| cs_n_i | input | 1 | Active-low chip-select |
| sck_i | input | 1 | Serial clock, either idle level |
| mosi_i | input | 1 | Serial data from host |
| miso_o | output | 1 | Serial data to host |
| miso_oe_o | output | 1 | MISO drive enable; low means high impedance |
| pin_i | input | 8 | Pin levels seen from outside |
| pin_o | output | 8 | Values driven on output pins |
| pin_oe_o | output | 8 | Per-pin output enable |

## Verification
The bound checker checks the following on every cycle. MISO is never enabled once chip-select has gone inactive. The pin output and pin enable vectors change only in the cycle after a write strobe to their own register. The flag is set whenever the comparator is armed and its condition holds, and it falls only after a control read strobe. The values themselves can only be shown by the bench's frames: the replace, set and clear arithmetic, the mixing of driven and sensed bits on a read, both clock polarities, identity rejection, aborted frames, and the flag surviving a condition that has lapsed.

// File: rtl/spi_gpio_pkg.sv
package spi_gpio_pkg;

  localparam int CMD_W       = 8;
  localparam int CTRL_W      = 8;
  localparam int RW_BIT      = 7;
  localparam int SEL_HI      = 4;
  localparam int SEL_LO      = 3;
  localparam int MODE_HI     = 1;
  localparam int MODE_LO     = 0;
  localparam int ID_LAST_CNT = 2;   // identity complete on third sampled bit
  localparam int CTRL_FLAG   = 4;
  localparam int CTRL_EN     = 2;

  typedef enum logic [1:0] {
    SEL_DATA = 2'b00,
    SEL_DIR  = 2'b01,
    SEL_CTRL = 2'b10,
    SEL_NONE = 2'b11
  } reg_sel_e;

  typedef enum logic [1:0] {
    WM_PUT  = 2'b00,
    WM_SET  = 2'b01,
    WM_CLR  = 2'b10,
    WM_PUTX = 2'b11
  } wmode_e;

  typedef enum logic [1:0] {
    CMP_EQ = 2'b00,
    CMP_NE = 2'b01,
    CMP_GT = 2'b10,
    CMP_LT = 2'b11
  } cmp_cond_e;

endpackage

// File: rtl/spi_gpio_sync.sv
module spi_gpio_sync #(
  parameter int             W       = 1,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stg [STAGES];

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    if (k == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[k] <= RST_VAL;
        else     stg[k] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[k] <= RST_VAL;
        else     stg[k] <= stg[k-1];
      end
    end
  end

  assign q_o = stg[STAGES-1];

endmodule

// File: rtl/spi_gpio_cmp.sv
module spi_gpio_cmp
  import spi_gpio_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] pins_i,
  input  logic [W-1:0] ref_i,
  input  cmp_cond_e    cond_i,
  output logic         hit_o
);

  always_comb begin
    unique case (cond_i)
      CMP_EQ:  hit_o = (pins_i == ref_i);
      CMP_NE:  hit_o = (pins_i != ref_i);
      CMP_GT:  hit_o = (pins_i >  ref_i);
      default: hit_o = (pins_i <  ref_i);
    endcase
  end

endmodule

// File: rtl/spi_gpio_frame.sv
module spi_gpio_frame
  import spi_gpio_pkg::*;
#(
  parameter int W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        id_i,
  input  logic              cs_n_s,
  input  logic              sck_s,
  input  logic              mosi_s,
  input  logic [CTRL_W-1:0] status_i,
  input  logic [W-1:0]      rdata_i,
  output logic              miso_o,
  output logic              miso_oe_o,
  output reg_sel_e          sel_o,
  output wmode_e            wmode_o,
  output logic              wr_stb_o,
  output logic [W-1:0]      wdata_o,
  output logic              rd_clr_o
);

  localparam int FRAME = CMD_W + W;
  localparam int TXW   = (W > CMD_W) ? W : CMD_W;
  localparam int CW    = $clog2(FRAME + 1);

  logic           cs_q, sck_q, idle_q, id_hit_q;
  logic [CW-1:0]  cnt;
  logic [TXW-2:0] rx;
  logic [TXW-1:0] tx;
  logic           cmd_wr;
  reg_sel_e       cmd_sel;
  wmode_e         cmd_mode;

  logic cs_act, start, sck_edge, lead, trail;

  assign cs_act   = ~cs_n_s;
  assign start    = cs_act & ~cs_q;
  assign sck_edge = sck_s ^ sck_q;
  assign lead     = cs_act & ~start & sck_edge & (sck_q == idle_q);
  assign trail    = cs_act & ~start & sck_edge & (sck_q != idle_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_q      <= 1'b0;
      sck_q     <= 1'b0;
      idle_q    <= 1'b0;
      id_hit_q  <= 1'b0;
      cnt       <= '0;
      rx        <= '0;
      tx        <= '0;
      cmd_wr    <= 1'b0;
      cmd_sel   <= SEL_DATA;
      cmd_mode  <= WM_PUT;
      miso_oe_o <= 1'b0;
      wr_stb_o  <= 1'b0;
      wdata_o   <= '0;
      rd_clr_o  <= 1'b0;
    end else begin
      cs_q      <= cs_act;
      sck_q     <= sck_s;
      wr_stb_o  <= 1'b0;
      rd_clr_o  <= 1'b0;
      miso_oe_o <= cs_act & id_hit_q;
      if (start) begin
        idle_q   <= sck_s;
        cnt      <= '0;
        id_hit_q <= 1'b0;
        tx       <= TXW'(status_i) << (TXW - CMD_W);
      end else if (!cs_act) begin
        cnt      <= '0;
        id_hit_q <= 1'b0;
      end else begin
        if (lead && cnt != CW'(FRAME)) begin
          rx  <= {rx[TXW-3:0], mosi_s};
          cnt <= cnt + 1'b1;
          if (cnt == CW'(ID_LAST_CNT))
            id_hit_q <= ({rx[0], mosi_s} == id_i);
          if (cnt == CW'(CMD_W - 1)) begin
            cmd_wr   <= rx[RW_BIT-1];
            cmd_sel  <= reg_sel_e'(rx[SEL_HI-1 -: 2]);
            cmd_mode <= wmode_e'({rx[MODE_HI-1], mosi_s});
          end
          if (cnt == CW'(FRAME - 1)) begin
            wr_stb_o <= id_hit_q & cmd_wr;
            wdata_o  <= {rx[W-2:0], mosi_s};
          end
        end
        if (trail) begin
          if (cnt == CW'(CMD_W)) begin
            tx       <= TXW'(rdata_i) << (TXW - W);
            rd_clr_o <= id_hit_q & ~cmd_wr & (cmd_sel == SEL_CTRL);
          end else begin
            tx <= tx << 1;
          end
        end
      end
    end
  end

  assign miso_o  = tx[TXW-1];
  assign sel_o   = cmd_sel;
  assign wmode_o = cmd_mode;

endmodule

// File: rtl/spi_gpio_regs.sv
module spi_gpio_regs
  import spi_gpio_pkg::*;
#(
  parameter int W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_stb_i,
  input  reg_sel_e          sel_i,
  input  wmode_e            wmode_i,
  input  logic [W-1:0]      wdata_i,
  input  logic              rd_clr_i,
  input  logic [W-1:0]      pin_s_i,
  input  logic              cmp_hit_i,
  output logic [W-1:0]      data_o,
  output logic [W-1:0]      dir_o,
  output cmp_cond_e         cond_o,
  output logic              cmp_en_o,
  output logic              flag_o,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic [W-1:0]      rdata_o
);

  logic [W-1:0] data_q, dir_q;
  cmp_cond_e    cond_q;
  logic         en_q, flag_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      dir_q  <= '0;
      cond_q <= CMP_EQ;
      en_q   <= 1'b0;
    end else if (wr_stb_i) begin
      unique case (sel_i)
        SEL_DATA: begin
          unique case (wmode_i)
            WM_SET:  data_q <= data_q | wdata_i;
            WM_CLR:  data_q <= data_q & ~wdata_i;
            default: data_q <= wdata_i;
          endcase
        end
        SEL_DIR:  dir_q <= wdata_i;
        SEL_CTRL: begin
          en_q   <= wdata_i[CTRL_EN];
          cond_q <= cmp_cond_e'(wdata_i[1:0]);
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                    flag_q <= 1'b0;
    else if (en_q && cmp_hit_i) flag_q <= 1'b1;
    else if (rd_clr_i)          flag_q <= 1'b0;
  end

  always_comb begin
    ctrl_o            = '0;
    ctrl_o[CTRL_FLAG] = flag_q;
    ctrl_o[CTRL_EN]   = en_q;
    ctrl_o[1:0]       = cond_q;
  end

  always_comb begin
    unique case (sel_i)
      SEL_DATA: rdata_o = (dir_q & data_q) | (~dir_q & pin_s_i);
      SEL_DIR:  rdata_o = dir_q;
      SEL_CTRL: rdata_o = W'(ctrl_o);
      default:  rdata_o = '0;
    endcase
  end

  assign data_o   = data_q;
  assign dir_o    = dir_q;
  assign cond_o   = cond_q;
  assign cmp_en_o = en_q;
  assign flag_o   = flag_q;

endmodule

// File: rtl/spi_gpio_expander.sv
module spi_gpio_expander
  import spi_gpio_pkg::*;
#(
  parameter int W           = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [1:0]   id_i,
  input  logic         cs_n_i,
  input  logic         sck_i,
  input  logic         mosi_i,
  output logic         miso_o,
  output logic         miso_oe_o,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] pin_o,
  output logic [W-1:0] pin_oe_o
);

  logic              cs_n_s, sck_s, mosi_s, cs_act;
  logic [W-1:0]      pin_s, rdata, wdata;
  logic [CTRL_W-1:0] ctrl_val;
  reg_sel_e          sel;
  wmode_e            wmode;
  cmp_cond_e         cond;
  logic              wr_stb, flag_clr, cmp_hit, cmp_en, cmp_flag;
  logic              wr_dir, wr_data;

  spi_gpio_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync_ser (
    .clk (clk),
    .rst (rst),
    .d_i ({cs_n_i, sck_i, mosi_i}),
    .q_o ({cs_n_s, sck_s, mosi_s})
  );

  spi_gpio_sync #(.W(W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_pin (
    .clk (clk),
    .rst (rst),
    .d_i (pin_i),
    .q_o (pin_s)
  );

  spi_gpio_frame #(.W(W)) u_frame (
    .clk       (clk),
    .rst       (rst),
    .id_i      (id_i),
    .cs_n_s    (cs_n_s),
    .sck_s     (sck_s),
    .mosi_s    (mosi_s),
    .status_i  (ctrl_val),
    .rdata_i   (rdata),
    .miso_o    (miso_o),
    .miso_oe_o (miso_oe_o),
    .sel_o     (sel),
    .wmode_o   (wmode),
    .wr_stb_o  (wr_stb),
    .wdata_o   (wdata),
    .rd_clr_o  (flag_clr)
  );

  spi_gpio_cmp #(.W(W)) u_cmp (
    .pins_i (pin_s),
    .ref_i  (pin_o),
    .cond_i (cond),
    .hit_o  (cmp_hit)
  );

  spi_gpio_regs #(.W(W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .wr_stb_i  (wr_stb),
    .sel_i     (sel),
    .wmode_i   (wmode),
    .wdata_i   (wdata),
    .rd_clr_i  (flag_clr),
    .pin_s_i   (pin_s),
    .cmp_hit_i (cmp_hit),
    .data_o    (pin_o),
    .dir_o     (pin_oe_o),
    .cond_o    (cond),
    .cmp_en_o  (cmp_en),
    .flag_o    (cmp_flag),
    .ctrl_o    (ctrl_val),
    .rdata_o   (rdata)
  );

  assign cs_act  = ~cs_n_s;
  assign wr_dir  = wr_stb & (sel == SEL_DIR);
  assign wr_data = wr_stb & (sel == SEL_DATA);

endmodule

// File: rtl/spi_gpio_expander_chk.sv
module spi_gpio_expander_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         cs_act,
  input logic         miso_oe_o,
  input logic [W-1:0] pin_o,
  input logic [W-1:0] pin_oe_o,
  input logic         wr_dir,
  input logic         wr_data,
  input logic         cmp_en,
  input logic         cmp_hit,
  input logic         cmp_flag,
  input logic         flag_clr
);

  assert_miso_idle_R5: assert property (@(posedge clk) disable iff (rst)
    !cs_act |=> !miso_oe_o);

  assert_dir_only_on_write_R8: assert property (@(posedge clk) disable iff (rst)
    !$stable(pin_oe_o) |-> $past(wr_dir));

  assert_data_only_on_write_R6: assert property (@(posedge clk) disable iff (rst)
    !$stable(pin_o) |-> $past(wr_data));

  assert_flag_sets_R9: assert property (@(posedge clk) disable iff (rst)
    (cmp_en && cmp_hit) |=> cmp_flag);

  assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    $fell(cmp_flag) |-> $past(flag_clr));

endmodule

bind spi_gpio_expander spi_gpio_expander_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cs_act    (cs_act),
  .miso_oe_o (miso_oe_o),
  .pin_o     (pin_o),
  .pin_oe_o  (pin_oe_o),
  .wr_dir    (wr_dir),
  .wr_data   (wr_data),
  .cmp_en    (cmp_en),
  .cmp_hit   (cmp_hit),
  .cmp_flag  (cmp_flag),
  .flag_clr  (flag_clr)
);

// File: tb/spi_gpio_expander_tb.sv
module spi_gpio_expander_tb;

  localparam int CLK_P = 10;
  localparam int HALF  = 6;
  localparam logic [1:0] MY_ID = 2'b10;

  typedef struct packed {
    logic       cpol;
    logic       wr;
    logic [1:0] sel;
    logic [1:0] md;
    logic [7:0] wd;
    logic [7:0] pins;
    logic       chk;
    logic [7:0] xst;
    logic [7:0] xrd;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b1, 2'd1, 2'd0, 8'h0F, 8'hA5, 1'b0, 8'h00, 8'h00},
    '{1'b0, 1'b0, 2'd1, 2'd0, 8'h00, 8'hA5, 1'b1, 8'h00, 8'h0F},
    '{1'b1, 1'b1, 2'd0, 2'd0, 8'h3C, 8'hA5, 1'b0, 8'h00, 8'h00},
    '{1'b1, 1'b0, 2'd0, 2'd0, 8'h00, 8'hA5, 1'b1, 8'h00, 8'hAC},
    '{1'b0, 1'b1, 2'd0, 2'd1, 8'hC1, 8'h00, 1'b0, 8'h00, 8'h00},
    '{1'b1, 1'b0, 2'd0, 2'd0, 8'h00, 8'h00, 1'b1, 8'h00, 8'h0D},
    '{1'b0, 1'b1, 2'd0, 2'd2, 8'h0C, 8'hFF, 1'b0, 8'h00, 8'h00},
    '{1'b0, 1'b0, 2'd0, 2'd0, 8'h00, 8'hFF, 1'b1, 8'h00, 8'hF1},
    '{1'b1, 1'b1, 2'd1, 2'd0, 8'hFF, 8'h00, 1'b0, 8'h00, 8'h00},
    '{1'b0, 1'b0, 2'd0, 2'd0, 8'h00, 8'h00, 1'b1, 8'h00, 8'hF1},
    '{1'b0, 1'b1, 2'd0, 2'd3, 8'h5A, 8'h00, 1'b0, 8'h00, 8'h00},
    '{1'b1, 1'b0, 2'd0, 2'd0, 8'h00, 8'h00, 1'b1, 8'h00, 8'h5A},
    '{1'b0, 1'b1, 2'd2, 2'd0, 8'hFB, 8'h00, 1'b0, 8'h00, 8'h00},
    '{1'b0, 1'b0, 2'd2, 2'd0, 8'h00, 8'h00, 1'b1, 8'h03, 8'h03}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cs_n = 1'b1;
  logic       sck = 1'b0;
  logic       mosi = 1'b0;
  logic [7:0] pins = 8'h00;
  logic       miso, miso_oe;
  logic [7:0] pin_o, pin_oe;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #(CLK_P/2) clk = ~clk;

  spi_gpio_expander u_dut (
    .clk       (clk),
    .rst       (rst),
    .id_i      (MY_ID),
    .cs_n_i    (cs_n),
    .sck_i     (sck),
    .mosi_i    (mosi),
    .miso_o    (miso),
    .miso_oe_o (miso_oe),
    .pin_i     (pins),
    .pin_o     (pin_o),
    .pin_oe_o  (pin_oe)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic xfer(input logic cpol, input logic [1:0] idv, input logic wr,
                      input logic [1:0] sel, input logic [1:0] md, input logic [7:0] wd,
                      input int nbits, output logic [7:0] st, output logic [7:0] rd,
                      output logic oe_seen);
    logic [15:0] fr;
    fr = {wr, idv, sel, 1'b0, md, wd};
    st = '0; rd = '0; oe_seen = 1'b0;
    @(negedge clk);
    sck  = cpol;
    mosi = fr[15];
    repeat (4) @(negedge clk);
    cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      if (i < 8) st = {st[6:0], miso};
      else       rd = {rd[6:0], miso};
      if (miso_oe) oe_seen = 1'b1;
      sck = ~cpol;
      repeat (HALF) @(negedge clk);
      sck = cpol;
      if (i < 15) mosi = fr[14-i];
      repeat (HALF) @(negedge clk);
    end
    cs_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    logic [7:0] st, rd;
    logic       oe;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);

    // R1: reset state
    check("R1 pin_o", pin_o, 8'h00);
    check("R1 pin_oe", pin_oe, 8'h00);
    check("R1 miso_oe", {7'd0, miso_oe}, 8'h00);
    xfer(1'b0, MY_ID, 1'b0, 2'd2, 2'd0, 8'h00, 16, st, rd, oe);
    check("R1 ctrl read", rd, 8'h00);

    // R2 R4 R6 R7 R13: vector walk
    foreach (VEC[k]) begin
      pins = VEC[k].pins;
      xfer(VEC[k].cpol, MY_ID, VEC[k].wr, VEC[k].sel, VEC[k].md, VEC[k].wd, 16, st, rd, oe);
      check($sformatf("R11 status vec%0d", k), st, VEC[k].xst);
      check($sformatf("R5 oe vec%0d", k), {7'd0, oe}, 8'h01);
      if (VEC[k].chk) check($sformatf("R2 R4 R6 R7 R13 read vec%0d", k), rd, VEC[k].xrd);
    end

    // R8: pins follow registers
    check("R8 pin_o", pin_o, 8'h5A);
    check("R8 pin_oe", pin_oe, 8'hFF);

    // R3: foreign identity ignored
    xfer(1'b0, 2'b01, 1'b1, 2'd0, 2'd0, 8'h00, 16, st, rd, oe);
    check("R3 no oe", {7'd0, oe}, 8'h00);
    xfer(1'b0, MY_ID, 1'b0, 2'd0, 2'd0, 8'h00, 16, st, rd, oe);
    check("R3 data kept", rd, 8'h5A);

    // R12: aborted frame
    xfer(1'b1, MY_ID, 1'b1, 2'd0, 2'd0, 8'h11, 12, st, rd, oe);
    check("R5 oe low after cs", {7'd0, miso_oe}, 8'h00);
    xfer(1'b0, MY_ID, 1'b0, 2'd0, 2'd0, 8'h00, 16, st, rd, oe);
    check("R12 data kept", rd, 8'h5A);
    check("R12 pin_o kept", pin_o, 8'h5A);

    // R9 R10: equal condition, sticky flag, clear on read
    pins = 8'h5A;
    xfer(1'b0, MY_ID, 1'b1, 2'd2, 2'd0, 8'h04, 16, st, rd, oe);
    xfer(1'b0, MY_ID, 1'b0, 2'd1, 2'd0, 8'h00, 16, st, rd, oe);
    check("R9 eq flag", st, 8'h14);
    pins = 8'h5B;
    xfer(1'b0, MY_ID, 1'b0, 2'd1, 2'd0, 8'h00, 16, st, rd, oe);
    check("R10 sticky", st, 8'h14);
    xfer(1'b1, MY_ID, 1'b0, 2'd2, 2'd0, 8'h00, 16, st, rd, oe);
    check("R10 ctrl read shows flag", rd, 8'h14);
    xfer(1'b0, MY_ID, 1'b0, 2'd1, 2'd0, 8'h00, 16, st, rd, oe);
    check("R10 cleared by read", st, 8'h04);

    // R9: differ condition
    xfer(1'b0, MY_ID, 1'b1, 2'd2, 2'd0, 8'h05, 16, st, rd, oe);
    xfer(1'b0, MY_ID, 1'b0, 2'd1, 2'd0, 8'h00, 16, st, rd, oe);
    check("R9 ne flag", st, 8'h15);
    pins = 8'h5A;
    xfer(1'b0, MY_ID, 1'b0, 2'd2, 2'd0, 8'h00, 16, st, rd, oe);
    xfer(1'b0, MY_ID, 1'b0, 2'd1, 2'd0, 8'h00, 16, st, rd, oe);
    check("R9 ne quiet", st, 8'h05);

    // R9: greater-than condition
    xfer(1'b0, MY_ID, 1'b1, 2'd2, 2'd0, 8'h06, 16, st, rd, oe);
    xfer(1'b0, MY_ID, 1'b0, 2'd1, 2'd0, 8'h00, 16, st, rd, oe);
    check("R9 gt quiet", st, 8'h06);
    pins = 8'h5B;
    xfer(1'b0, MY_ID, 1'b0, 2'd1, 2'd0, 8'h00, 16, st, rd, oe);
    check("R9 gt flag", st, 8'h16);
    pins = 8'h5A;
    xfer(1'b0, MY_ID, 1'b0, 2'd2, 2'd0, 8'h00, 16, st, rd, oe);

    // R9: less-than condition
    pins = 8'h59;
    xfer(1'b0, MY_ID, 1'b1, 2'd2, 2'd0, 8'h07, 16, st, rd, oe);
    xfer(1'b0, MY_ID, 1'b0, 2'd1, 2'd0, 8'h00, 16, st, rd, oe);
    check("R9 lt flag", st, 8'h17);

    summary();
  end

endmodule